// File: doc/BRIEF.md
# Expanding Opcode Instruction Decoder

This block takes an instruction stream one byte at a time and finds where each instruction ends. The first byte of an instruction is an opcode. A single reserved escape value says that a second opcode byte follows. Any other value is a complete one-byte opcode. From the opcode, the decoder works out how many immediate bytes belong to the instruction. It consumes those bytes and then reports the opcode, the opcode length and the total instruction length in one pulse. The byte after that pulse is always taken as the start of the next instruction.

Bytes arrive over a valid/ready handshake. The decoder accepts a byte on every clock edge where both valid and ready are high. It drops ready for the single cycle in which it presents a finished instruction. Opcodes that are not in the table are reported as illegal. They take up only their opcode bytes. An instruction that would grow past the length cap is cut short at the cap and marked with an error flag. Decoding then resumes at the following byte. Operand execution and memory access happen elsewhere.

Top module: `xop_decoder`

## Requirements
- R1: After synchronous active-low reset, `done` is low and `in_ready` is high. The next accepted byte is treated as a first opcode byte.
- R2: A first byte other than the escape value 0x0F is a complete opcode. At `done`, `opc_len` = 1 and `opcode` = {8'h00, byte}.
- R3: A first byte equal to 0x0F causes one more opcode byte s to be read. At `done`, `opc_len` = 2 and `opcode` = {8'h0F, s}.
- R4: A legal one-byte opcode b carries an immediate count set by b[7:6]: 00 gives 0 bytes, 01 gives 1, 10 gives 2, 11 gives 4. `instr_len` = 1 + count.
- R5: A legal second opcode byte s (s[7] = 0) carries s[3:0] immediate bytes. `instr_len` = 2 + s[3:0].
- R6: A one-byte opcode with b[5:4] = 11, or a second byte with s[7] = 1, is illegal. `illegal` is high and `instr_len` = `opc_len`. No immediate bytes are consumed, so the next byte is a new first opcode byte.
- R7: `done` goes high for exactly one cycle, in the cycle after the last byte of an instruction is accepted. `in_ready` is low in that cycle and high in every other cycle.
- R8: If an instruction would be longer than 15 bytes, `done` follows the 15th accepted byte with `overlong` = 1 and `instr_len` = 15. The next byte is a new first opcode byte. In all other cases `overlong` = 0 at `done`.
- R9: A cycle with `in_valid` low consumes no byte and does not produce `done`. Decoding continues unchanged when bytes resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A stream byte is offered |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| done | output | 1 | One-cycle pulse: a decoded instruction is presented |
| opcode | output | 16 | Opcode, escape byte in the upper half for two-byte opcodes |
| opc_len | output | 2 | Opcode length in bytes (1 or 2) |
| instr_len | output | 4 | Total instruction length in bytes |
| illegal | output | 1 | Opcode not in the table |
| overlong | output | 1 | Instruction was cut at the 15-byte cap |

## Verification
The assertions check on every cycle that `done` never lasts two cycles and only ever follows an accepted byte. They also check that an idle input cycle never yields `done`, and that the reported lengths agree with each other. In particular, an illegal opcode reports its opcode length as its instruction length, a capped instruction reports 15, and a two-byte opcode carries the escape byte. Only the bench scenarios can show that the immediate counts match the table and that instruction boundaries stay aligned across escapes, stalls, illegal codes and capped instructions. They also show the exact cycle in which each instruction is reported.

// File: rtl/xop_pkg.sv
// Shared types for the expanding-opcode decoder.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package xop_pkg;

    // Decoder phase: first opcode byte, second opcode byte, immediates, report.
    typedef enum logic [1:0] {
        ST_OP1  = 2'd0,
        ST_OP2  = 2'd1,
        ST_IMM  = 2'd2,
        ST_EMIT = 2'd3
    } xop_state_e;

endpackage

// File: rtl/xop_table.sv
// Opcode table: classifies one opcode byte as legal or illegal and gives
// its immediate byte count. Purely combinational.
// Assumes BYTE_W >= 8 and CNT_W >= 4 so the largest count (15) fits.
module xop_table #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [BYTE_W-1:0] code,
    input  logic              second,
    output logic [CNT_W-1:0]  imm_cnt,
    output logic              illegal
);

    logic [CNT_W-1:0] raw_cnt;

    // Look up legality and immediate count for a first or second opcode byte.
    always_comb begin
        if (second) begin
            illegal = code[7];
            raw_cnt = CNT_W'(code[3:0]);
        end else begin
            illegal = (code[5:4] == 2'b11);
            case (code[7:6])
                2'b00:   raw_cnt = CNT_W'(0);
                2'b01:   raw_cnt = CNT_W'(1);
                2'b10:   raw_cnt = CNT_W'(2);
                default: raw_cnt = CNT_W'(4);
            endcase
        end
    end

    // Illegal opcodes own no immediates.
    assign imm_cnt = illegal ? '0 : raw_cnt;

endmodule

// File: rtl/xop_lencnt.sv
// Length tracker: counts bytes taken for the current instruction and the
// immediates still owed. It flags the last immediate and the byte that
// reaches the length cap. Assumes MAX_LEN fits in LEN_W bits.
module xop_lencnt #(
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic [LEN_W-1:0] load_rem,
    input  logic             step,
    output logic [LEN_W-1:0] len,
    output logic             rem_last,
    output logic             at_cap
);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rem_q;

    // Load on an opcode byte, step once per accepted immediate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            len_q <= load_len;
            rem_q <= load_rem;
        end else if (step) begin
            len_q <= len_q + LEN_W'(1);
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    assign len      = len_q;
    assign rem_last = (rem_q == LEN_W'(1));
    assign at_cap   = (len_q == LEN_W'(MAX_LEN - 1));

endmodule

// File: rtl/xop_decoder.sv
// Expanding-opcode decoder top. It takes a byte stream over valid/ready,
// reads one opcode byte or an escape plus a second opcode byte, and then
// consumes the immediates named by the table. It reports each instruction
// with a one-cycle done pulse, and ready is low in that cycle.
// Assumes MAX_LEN > 5 so that only escaped opcodes can reach the cap.
module xop_decoder
    import xop_pkg::*;
#(
    parameter int              BYTE_W   = 8,
    parameter int              MAX_LEN  = 15,
    parameter logic [BYTE_W-1:0] ESC_CODE = 8'h0F,
    localparam int             OPC_W    = 2 * BYTE_W,
    localparam int             LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              done,
    output logic [OPC_W-1:0]  opcode,
    output logic [1:0]        opc_len,
    output logic [LEN_W-1:0]  instr_len,
    output logic              illegal,
    output logic              overlong
);

    xop_state_e       state_q, state_d;
    logic             accept;
    logic             is_esc;
    logic [LEN_W-1:0] imm_cnt;
    logic             tbl_illegal;
    logic             cnt_load;
    logic [LEN_W-1:0] cnt_load_len;
    logic             cnt_step;
    logic [LEN_W-1:0] cur_len;
    logic             rem_last;
    logic             at_cap;
    logic [OPC_W-1:0] opc_q;
    logic [1:0]       olen_q;
    logic             ill_q;
    logic             ovf_q;

    assign in_ready = (state_q != ST_EMIT);
    assign accept   = in_valid && in_ready;
    assign is_esc   = (in_byte == ESC_CODE);

    xop_table #(
        .BYTE_W (BYTE_W),
        .CNT_W  (LEN_W)
    ) u_table (
        .code    (in_byte),
        .second  (state_q == ST_OP2),
        .imm_cnt (imm_cnt),
        .illegal (tbl_illegal)
    );

    xop_lencnt #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN)
    ) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_len (cnt_load_len),
        .load_rem (imm_cnt),
        .step     (cnt_step),
        .len      (cur_len),
        .rem_last (rem_last),
        .at_cap   (at_cap)
    );

    // Next phase and counter controls from the accepted byte.
    always_comb begin
        state_d      = state_q;
        cnt_load     = 1'b0;
        cnt_load_len = LEN_W'(1);
        cnt_step     = 1'b0;
        case (state_q)
            ST_OP1: if (accept) begin
                cnt_load = 1'b1;
                if (is_esc)              state_d = ST_OP2;
                else if (imm_cnt == '0)  state_d = ST_EMIT;
                else                     state_d = ST_IMM;
            end
            ST_OP2: if (accept) begin
                cnt_load     = 1'b1;
                cnt_load_len = LEN_W'(2);
                state_d      = (imm_cnt == '0) ? ST_EMIT : ST_IMM;
            end
            ST_IMM: if (accept) begin
                cnt_step = 1'b1;
                if (rem_last || at_cap) state_d = ST_EMIT;
            end
            default: state_d = ST_OP1;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OP1;
        else        state_q <= state_d;
    end

    // Capture opcode, opcode length and flags as the instruction is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q  <= '0;
            olen_q <= 2'd0;
            ill_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (accept) begin
            if (state_q == ST_OP1) begin
                ovf_q <= 1'b0;
                if (!is_esc) begin
                    opc_q  <= {{(OPC_W-BYTE_W){1'b0}}, in_byte};
                    olen_q <= 2'd1;
                    ill_q  <= tbl_illegal;
                end
            end else if (state_q == ST_OP2) begin
                opc_q  <= {ESC_CODE, in_byte};
                olen_q <= 2'd2;
                ill_q  <= tbl_illegal;
            end else if (state_q == ST_IMM) begin
                if (at_cap && !rem_last) ovf_q <= 1'b1;
            end
        end
    end

    assign done      = (state_q == ST_EMIT);
    assign opcode    = opc_q;
    assign opc_len   = olen_q;
    assign instr_len = cur_len;
    assign illegal   = ill_q;
    assign overlong  = ovf_q;

    // R7: the report pulse lasts one cycle.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a report always follows an accepted byte.
    assert_done_after_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_ready));

    // R9: an idle input cycle never completes an instruction.
    assert_idle_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !done);

    // R8: reported length stays within the cap and covers the opcode.
    assert_len_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (instr_len <= LEN_W'(MAX_LEN) && instr_len >= LEN_W'(opc_len)));

    // R8: a cut instruction reports exactly the cap.
    assert_ovf_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overlong) |-> (instr_len == LEN_W'(MAX_LEN)));

    // R6: an illegal opcode owns no immediates.
    assert_illegal_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (instr_len == LEN_W'(opc_len)));

    // R3: a two-byte opcode carries the escape byte on top.
    assert_esc_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && opc_len == 2'd2) |-> (opcode[OPC_W-1 -: BYTE_W] == ESC_CODE));

endmodule

// File: tb/sim_xop_decoder.sv
`timescale 1ns/1ps
// Bench for xop_decoder: a behavioural cycle model fed from a byte queue,
// compared with the design at every falling edge.
module sim_xop_decoder;

    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        done;
    logic [15:0] opcode;
    logic [1:0]  opc_len;
    logic [3:0]  instr_len;
    logic        illegal;
    logic        overlong;

    always #2 clk = ~clk;

    xop_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .done(done), .opcode(opcode), .opc_len(opc_len),
        .instr_len(instr_len), .illegal(illegal), .overlong(overlong)
    );

    int n_chk = 0;
    int n_fail = 0;
    int stim[$];

    // Model state: 0 first byte, 1 second byte, 2 immediates, 3 reporting.
    int m_st = 0, m_len = 0, m_rem = 0, m_opc = 0, m_olen = 0;
    bit m_ill = 0, m_ovf = 0;
    bit prev_idle = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int first_imm(input int b);
        case ((b >> 6) & 3)
            0: return 0;
            1: return 1;
            2: return 2;
            default: return 4;
        endcase
    endfunction

    task automatic add(input int b);
        stim.push_back(b & 255);
    endtask

    task automatic add_n(input int b, input int n);
        for (int i = 0; i < n; i++) add(b);
    endtask

    // Advance the model one clock, given whether a byte b is accepted.
    task automatic model_step(input bit acc, input int b);
        if (m_st == 3) begin
            m_st = 0;
        end else if (acc) begin
            case (m_st)
                0: begin
                    m_len = 1;
                    m_ovf = 0;
                    if (b == 15) m_st = 1;
                    else begin
                        m_opc = b; m_olen = 1;
                        m_ill = (((b >> 4) & 3) == 3);
                        m_rem = m_ill ? 0 : first_imm(b);
                        m_st = (m_rem == 0) ? 3 : 2;
                    end
                end
                1: begin
                    m_len = 2;
                    m_opc = 15 * 256 + b; m_olen = 2;
                    m_ill = ((b & 128) != 0);
                    m_rem = m_ill ? 0 : (b & 15);
                    m_st = (m_rem == 0) ? 3 : 2;
                end
                default: begin
                    m_len++;
                    m_rem--;
                    if (m_rem == 0) m_st = 3;
                    else if (m_len == 15) begin m_ovf = 1; m_st = 3; end
                end
            endcase
        end
    endtask

    initial begin
        int cyc = 0;
        bit phase_rand = 0;
        // Directed: plain, each immediate size, illegal, escaped, exact cap, cut.
        add(8'h00);                       // R2/R4 no immediates
        add(8'h41); add(8'hAA);           // R4 one immediate
        add(8'h82); add_n(8'h11, 2);      // R4 two immediates
        add(8'hC3); add_n(8'h22, 4);      // R4 four immediates
        add(8'h30);                       // R6 illegal first byte
        add(8'hF1); add_n(8'h33, 4);      // R6 illegal first byte 0xF1
        add(8'h0F); add(8'h05); add_n(8'h44, 5);  // R3/R5
        add(8'h0F); add(8'h80);           // R6 illegal second byte
        add(8'h0F); add(8'h70);           // R3 legal, no immediates
        add(8'h0F); add(8'h0D); add_n(8'h55, 13); // R5 exactly 15
        add(8'h0F); add(8'h0E); add_n(8'h00, 14); // R8 cut, one spare byte
        add(8'h0F); add(8'h0F); add_n(8'h00, 15); // R8 cut, two spare bytes
        add(8'h0F); add(8'h0F);           // R3 escape as second byte
        add_n(8'h00, 15);
        for (int i = 0; i < 400; i++) add($urandom_range(0, 255));
        add_n(8'h00, 20);

        // R1: reset state.
        repeat (3) begin
            @(negedge clk);
            chk(done == 1'b0, "R1", "done in reset", done, 0);
            chk(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
        end
        rst_n = 1'b1;

        while ((stim.size() > 0 || m_st != 0) && cyc < LIMIT) begin
            bit acc;
            int b;
            @(negedge clk);
            cyc++;
            if (cyc > 60) phase_rand = 1;
            chk(done == (m_st == 3), prev_idle ? "R9" : "R7", "done", done, m_st == 3);
            chk(in_ready == (m_st != 3), "R7", "ready", in_ready, m_st != 3);
            if (done && m_st == 3) begin
                string lreq;
                lreq = m_ovf ? "R8" : (m_ill ? "R6" : (m_olen == 2 ? "R5" : "R4"));
                chk(opc_len == m_olen, m_olen == 2 ? "R3" : "R2", "opc_len", opc_len, m_olen);
                chk(opcode == m_opc, m_olen == 2 ? "R3" : "R2", "opcode", opcode, m_opc);
                chk(instr_len == (m_ovf ? 15 : (m_ill ? m_olen : m_len)), lreq,
                    "instr_len", instr_len, m_ovf ? 15 : (m_ill ? m_olen : m_len));
                chk(illegal == m_ill, "R6", "illegal", illegal, m_ill);
                chk(overlong == m_ovf, "R8", "overlong", overlong, m_ovf);
            end
            // Drive next byte, with stall gaps.
            if (stim.size() > 0 && ($urandom_range(0, phase_rand ? 3 : 5) != 0)) begin
                in_valid = 1'b1;
                in_byte  = stim[0][7:0];
            end else begin
                in_valid = 1'b0;
                in_byte  = 8'h5A;
            end
            acc = in_valid && (m_st != 3);
            b = in_byte;
            if (acc) void'(stim.pop_front());
            prev_idle = !in_valid && (m_st != 3);
            model_step(acc, b);
        end

        if (cyc >= LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, LIMIT);
        end

        // R9: with no input, nothing more is reported.
        in_valid = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(done == 1'b0, "R9", "done while idle", done, 0);
            chk(in_ready == 1'b1, "R9", "ready while idle", in_ready, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule